// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers single-cycle event pulses from up to sixteen internal sources into a sticky pending register. It raises one interrupt line toward a host processor. The host uses a small register bus to work with it. Over that bus it can mask sources, inspect which events are pending and retire them.

Pending bits can be retired in two ways. A clear-on-read status view empties the whole register in one access. A write-one acknowledge port retires only the bits the host names. The mask can be written whole, or bits can be set or cleared one at a time through write-only strobes, with no read-modify-write. The output line is enabled and its polarity chosen by a configuration register.

The default source numbering is:
- bit 0: receive buffer 0 data
- bit 1: transmit data
- bit 2: transmit transfer
- bit 3: receive buffer 1 data
- bit 4: receive transfer
- bits 5 and 6: event mailbox
- bit 7: wake
- bits 8 and 9: debug trace
- bit 10: command complete
- bit 14: initialization complete

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0x0001 (only source 0 blocked), the pending register reads 0, the configuration reads 0, `irq_o` is low and `rd_data_o` is 0.
- R2: The mask view at address 0 is read/write. A write loads bits [NUM_SRC-1:0]. Bits above NUM_SRC-1 are dropped and read back as 0.
- R3: A write to the mask-set port at address 1 sets every mask bit written as 1 and leaves the other mask bits unchanged.
- R4: A write to the mask-clear port at address 2 clears every mask bit written as 1 and leaves the other mask bits unchanged.
- R5: A 1 on `event_i[k]` for one cycle sets pending bit k, which then stays set. A read of the peek view at address 3 returns the pending bits in `rd_data_o` on the cycle after `rd_en_i`, and leaves them unchanged.
- R6: A read of the take view at address 4 returns the pending bits, as in R5, and clears all of them.
- R7: A write to the acknowledge port at address 5 clears each pending bit written as 1. Bits written as 0 have no effect.
- R8: If an event pulse for bit k arrives in the same cycle as a take read or an acknowledge of bit k, bit k stays set after that cycle.
- R9: The configuration register at address 6 holds an enable in bit 0 and an active-low select in bit 1. `irq_o` equals (OR over pending bits whose mask bit is 0) AND enable, inverted when bit 1 is 1.
- R10: Reads of the write-only ports (addresses 1, 2 and 5) and of the unmapped address 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | NUM_SRC | Event pulses, one per source |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, registered, valid the cycle after rd_en_i |
| irq_o | output | 1 | Host interrupt line |

## Verification
A corrupted mask or pending bit shows up at the next read of the mask or peek view, one cycle after the read strobe. If the bit is unmasked, it also shows on `irq_o` in the cycle after the event or clearing access. Dropping an event that collides with a clear shows up as a missing bit at the following peek. A clear that leaks into the wrong bits shows up the same way, as a changed value at the following peek. Polarity or enable faults appear on `irq_o` in the cycle after the configuration write, with no event needed.

// File: rtl/hisc_pkg.sv
package hisc_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_MASK     = 3'd0,
    RA_MASK_SET = 3'd1,
    RA_MASK_CLR = 3'd2,
    RA_PEEK     = 3'd3,
    RA_TAKE     = 3'd4,
    RA_ACK      = 3'd5,
    RA_CFG      = 3'd6,
    RA_NONE     = 3'd7
  } reg_addr_e;

  // source numbering
  localparam int SRC_RX0_DATA  = 0;
  localparam int SRC_TX_DATA   = 1;
  localparam int SRC_TX_XFER   = 2;
  localparam int SRC_RX1_DATA  = 3;
  localparam int SRC_RX_XFER   = 4;
  localparam int SRC_MBOX_A    = 5;
  localparam int SRC_MBOX_B    = 6;
  localparam int SRC_WAKE      = 7;
  localparam int SRC_TRACE_A   = 8;
  localparam int SRC_TRACE_B   = 9;
  localparam int SRC_CMD_DONE  = 10;
  localparam int SRC_INIT_DONE = 14;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_LOW_BIT = 1;

  typedef struct packed {
    logic en;
    logic act_low;
  } line_cfg_t;
endpackage

// File: rtl/hisc_mask_bank.sv
module hisc_mask_bank #(
  parameter int NUM_SRC = 16,
  parameter logic [NUM_SRC-1:0] RST_VAL = NUM_SRC'(1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic [NUM_SRC-1:0] data_i,
  output logic [NUM_SRC-1:0] mask_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  bit_q <= RST_VAL[k];
      else if (load_i)              bit_q <= data_i[k];
      else if (set_i && data_i[k])  bit_q <= 1'b1;
      else if (clr_i && data_i[k])  bit_q <= 1'b0;
    end
    assign mask_o[k] = bit_q;
  end
endmodule

// File: rtl/hisc_pend_bank.sv
module hisc_pend_bank #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               take_i,
  input  logic               ack_i,
  input  logic [NUM_SRC-1:0] ack_bits_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    logic bit_q;
    logic drop;
    assign drop = take_i | (ack_i & ack_bits_i[k]);
    // a fresh event beats any clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         bit_q <= 1'b0;
      else if (event_i[k]) bit_q <= 1'b1;
      else if (drop)       bit_q <= 1'b0;
    end
    assign pend_o[k] = bit_q;
  end
endmodule

// File: rtl/hisc_line_drv.sv
module hisc_line_drv
  import hisc_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  line_cfg_t          cfg_i,
  output logic               irq_o
);
  logic any_live;
  assign any_live = |(pend_i & ~mask_i);
  assign irq_o    = (any_live & cfg_i.en) ^ cfg_i.act_low;
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import hisc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o
);
  localparam logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1);

  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] status_q;
  logic               cfg_en_q;
  logic               cfg_low_q;
  line_cfg_t          line_cfg;
  logic [DATA_W-1:0]  rd_view;
  logic [DATA_W-1:0]  rd_q;

  logic hit_mask, hit_set, hit_clr, hit_peek, hit_take, hit_ack, hit_cfg;

  assign wbits    = wr_data_i[NUM_SRC-1:0];
  assign hit_mask = addr_i == ADDR_W'(RA_MASK);
  assign hit_set  = addr_i == ADDR_W'(RA_MASK_SET);
  assign hit_clr  = addr_i == ADDR_W'(RA_MASK_CLR);
  assign hit_peek = addr_i == ADDR_W'(RA_PEEK);
  assign hit_take = addr_i == ADDR_W'(RA_TAKE);
  assign hit_ack  = addr_i == ADDR_W'(RA_ACK);
  assign hit_cfg  = addr_i == ADDR_W'(RA_CFG);

  if (DATA_W > NUM_SRC) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^wr_data_i[DATA_W-1:NUM_SRC];
  end

  hisc_mask_bank #(.NUM_SRC(NUM_SRC), .RST_VAL(MASK_RST)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_en_i & hit_mask),
    .set_i  (wr_en_i & hit_set),
    .clr_i  (wr_en_i & hit_clr),
    .data_i (wbits),
    .mask_o (mask_q)
  );

  hisc_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (event_i),
    .take_i     (rd_en_i & hit_take),
    .ack_i      (wr_en_i & hit_ack),
    .ack_bits_i (wbits),
    .pend_o     (status_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_en_q  <= 1'b0;
      cfg_low_q <= 1'b0;
    end else if (wr_en_i && hit_cfg) begin
      cfg_en_q  <= wr_data_i[CFG_EN_BIT];
      cfg_low_q <= wr_data_i[CFG_LOW_BIT];
    end
  end

  assign line_cfg = '{en: cfg_en_q, act_low: cfg_low_q};

  hisc_line_drv #(.NUM_SRC(NUM_SRC)) u_line (
    .pend_i (status_q),
    .mask_i (mask_q),
    .cfg_i  (line_cfg),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_view = '0;
    if (hit_mask)                 rd_view = DATA_W'(mask_q);
    else if (hit_peek || hit_take) rd_view = DATA_W'(status_q);
    else if (hit_cfg) begin
      rd_view[CFG_EN_BIT]  = cfg_en_q;
      rd_view[CFG_LOW_BIT] = cfg_low_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_view;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/host_irq_ctrl_chk.sv
module host_irq_ctrl_chk #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] event_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] status_q,
  input logic               cfg_en_q,
  input logic               cfg_low_q
);
  // R3
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(1)) |=>
      ((mask_q & $past(wr_data_i[NUM_SRC-1:0])) == $past(wr_data_i[NUM_SRC-1:0]))
      && ((mask_q & ~$past(wr_data_i[NUM_SRC-1:0])) == ($past(mask_q) & ~$past(wr_data_i[NUM_SRC-1:0]))));

  // R4
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(2)) |=>
      ((mask_q & $past(wr_data_i[NUM_SRC-1:0])) == '0)
      && ((mask_q & ~$past(wr_data_i[NUM_SRC-1:0])) == ($past(mask_q) & ~$past(wr_data_i[NUM_SRC-1:0]))));

  // R5
  peek_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(3) && event_i == '0 && !wr_en_i) |=>
      $stable(status_q) && rd_data_o == DATA_W'($past(status_q)));

  // R6
  take_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(4)) |=> (status_q & ~$past(event_i)) == '0);

  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(5)) |=>
      (status_q & $past(wr_data_i[NUM_SRC-1:0]) & ~$past(event_i)) == '0);

  // R8
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> (status_q & $past(event_i)) == $past(event_i));

  // R9
  line_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en_q || (status_q & ~mask_q) == '0) |-> irq_o == cfg_low_q);

  // R10
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == ADDR_W'(1) || addr_i == ADDR_W'(2) ||
                 addr_i == ADDR_W'(5) || addr_i == ADDR_W'(7))) |=> rd_data_o == '0);
endmodule

bind host_irq_ctrl host_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/host_irq_ctrl_bench.sv
`timescale 1ns/1ps
module host_irq_ctrl_bench;
  localparam int NS = 16;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] event_s = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  host_irq_ctrl #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) u_host_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .event_i(event_s), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
    .irq_o(irq)
  );

  // op: 0 write, 1 read+compare, 2 event pulse
  typedef struct packed {
    logic [1:0]    op;
    logic [3:0]    req;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 4'd1,  3'd0, 32'h0000_0001}, // R1 mask reset
    '{2'd1, 4'd1,  3'd3, 32'h0000_0000}, // R1 pending reset
    '{2'd0, 4'd2,  3'd0, 32'hFFFF_00F0}, // R2
    '{2'd1, 4'd2,  3'd0, 32'h0000_00F0}, // R2 upper bits dropped
    '{2'd0, 4'd3,  3'd1, 32'h0000_0103}, // R3
    '{2'd1, 4'd3,  3'd0, 32'h0000_01F3}, // R3
    '{2'd0, 4'd4,  3'd2, 32'h0000_0030}, // R4
    '{2'd1, 4'd4,  3'd0, 32'h0000_01C3}, // R4
    '{2'd2, 4'd5,  3'd0, 32'h0000_0421}, // R5
    '{2'd2, 4'd5,  3'd0, 32'h0000_4000}, // R5 sticky accumulate
    '{2'd1, 4'd5,  3'd3, 32'h0000_4421}, // R5
    '{2'd1, 4'd5,  3'd3, 32'h0000_4421}, // R5 peek left it alone
    '{2'd0, 4'd7,  3'd5, 32'h0000_0020}, // R7
    '{2'd1, 4'd7,  3'd3, 32'h0000_4401}, // R7
    '{2'd0, 4'd7,  3'd5, 32'h0000_0000}, // R7 zeros no effect
    '{2'd1, 4'd7,  3'd3, 32'h0000_4401}, // R7
    '{2'd1, 4'd6,  3'd4, 32'h0000_4401}, // R6 take returns
    '{2'd1, 4'd6,  3'd3, 32'h0000_0000}, // R6 then cleared
    '{2'd1, 4'd10, 3'd1, 32'h0000_0000}, // R10
    '{2'd1, 4'd10, 3'd2, 32'h0000_0000}, // R10
    '{2'd1, 4'd10, 3'd5, 32'h0000_0000}, // R10
    '{2'd1, 4'd10, 3'd7, 32'h0000_0000}, // R10
    '{2'd0, 4'd9,  3'd6, 32'h0000_0003}, // R9
    '{2'd1, 4'd9,  3'd6, 32'h0000_0003}  // R9
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NS-1:0] ev = '0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; event_s = ev;
    @(negedge clk);
    wr_en = 1'b0; event_s = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v, input logic [NS-1:0] ev = '0);
    @(negedge clk);
    rd_en = 1'b1; addr = a; event_s = ev;
    @(negedge clk);
    rd_en = 1'b0; event_s = '0;
    v = rdata;
  endtask

  task automatic pulse(input logic [NS-1:0] ev);
    @(negedge clk);
    event_s = ev;
    @(negedge clk);
    event_s = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 outputs after reset
    check("R1 irq", DW'(irq), 0);
    check("R1 rdata", rdata, 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].a, VEC[i].d);
        2'd2: pulse(VEC[i].d[NS-1:0]);
        default: begin
          rd(VEC[i].a, v);
          check($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].d);
        end
      endcase
    end

    // R9: mask=0x01C3, pending=0, cfg enable+active-low
    check("R9 idle active-low", DW'(irq), 1);
    wr(3'd6, 32'h1);
    check("R9 idle active-high", DW'(irq), 0);
    pulse(16'h0001);
    check("R9 masked source", DW'(irq), 0);
    pulse(16'h0004);
    check("R9 unmasked source", DW'(irq), 1);
    wr(3'd6, 32'h3);
    check("R9 inverted", DW'(irq), 0);
    wr(3'd6, 32'h0);
    check("R9 disabled", DW'(irq), 0);

    // R8: collisions, pending=0x0005
    wr(3'd5, 32'h0004, 16'h0004);
    rd(3'd3, v);
    check("R8 ack vs event", v, 32'h0005);
    rd(3'd4, v, 16'h0008);
    check("R8 take returns old", v, 32'h0005);
    rd(3'd3, v);
    check("R8 take vs event", v, 32'h0008);
    wr(3'd5, 32'h0008, 16'h0010);
    rd(3'd3, v);
    check("R7 ack one, event other", v, 32'h0010);

    // R1: reset mid-run
    wr(3'd6, 32'h2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 irq after reset", DW'(irq), 0);
    check("R1 rdata after reset", rdata, 0);
    rd(3'd0, v);
    check("R1 mask after reset", v, 32'h1);
    rd(3'd3, v);
    check("R1 pending after reset", v, 32'h0);
    rd(3'd6, v);
    check("R1 cfg after reset", v, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule